// File: doc/BRIEF.md
# Two-Channel Converter Sample Lane Serializer

This block sits behind a two-channel data converter and turns the parallel samples into bit streams on two serial lanes, with a frame clock that marks word boundaries. Once per frame it captures one sample from each channel, cuts or pads each sample to the selected output width, and shifts the words out MSB first on a single-data-rate bit clock.

Each channel's sample arrives as a 20-bit word with a flag. With the flag clear the word is a raw 18-bit converter sample held in the low bits. With the flag set the word is a full 20-bit filtered result. The output width can be 14, 16, 18 or 20 bits. The lane mode sets how the two words share the lanes: each word split over both lanes, one lane per channel, or both words one after the other on a single lane. The frame length follows from the mode and the width, and the bit clock has to be set to match.

Mode, width and samples are all taken at the same clock edge, once per frame. A setting that changes partway through a frame therefore only takes effect on the next frame.

Top module: `adc_lane_serializer`

## Requirements
- R1: While `arst_n` is low, `lane0`, `lane1` and `fclk` are 0. After `arst_n` rises between two clock edges, `fclk` stays 0 after the first three rising edges and is 1 after the fourth, which carries bit 0 of the first frame.
- R2: `res_sel` selects the output width W: 2'b00 gives 18 bits (the default code), 2'b01 gives 14, 2'b10 gives 16 and 2'b11 gives 20. To build the extended word, a sample with its flag at 0 is placed as `{sample[17:0],2'b00}`, and a sample with its flag at 1 is used as `sample[19:0]`. The output word is the top W bits of the extended word.
- R3: With `lane_mode` 2'b00 (2-wire) a frame lasts W bit clocks. The first W/2 bit clocks carry channel A and the last W/2 carry channel B. For each word, `lane0` sends the upper W/2 bits and `lane1` the lower W/2 bits, both MSB first.
- R4: With `lane_mode` 2'b01 (1-wire) a frame lasts W bit clocks. `lane0` sends the channel A word and `lane1` the channel B word, both MSB first. Code 2'b11 behaves exactly like 2'b01.
- R5: `fclk` is 1 for the first half of every frame and 0 for the second half. It rises together with bit 0 of the frame.
- R6: With `lane_mode` 2'b10 (1/2-wire) a frame lasts 2W bit clocks. `lane0` sends the channel A word and then the channel B word, MSB first, and `lane1` stays 0.
- R7: Frames follow each other with no idle bit clock between them. The samples, flags, `res_sel` and `lane_mode` are all sampled at the rising edge one cycle before bit 0 of the frame appears.
- R8: A change to the samples, flags, `res_sel` or `lane_mode` during a frame leaves that frame's bits and `fclk` unchanged. The change takes effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Single-data-rate bit clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| smp_a | input | 20 | Channel A sample word |
| smp_b | input | 20 | Channel B sample word |
| filt_a | input | 1 | 1: channel A word is a 20-bit filtered result |
| filt_b | input | 1 | 1: channel B word is a 20-bit filtered result |
| res_sel | input | 2 | Output width select |
| lane_mode | input | 2 | Lane mode select |
| lane0 | output | 1 | Serial data lane 0 |
| lane1 | output | 1 | Serial data lane 1 |
| fclk | output | 1 | Frame clock |

## Verification
A bit counter that drifts or a frame length computed wrongly appears first at `fclk`: within one frame its rising or falling edge lands on the wrong bit clock, and the next frame no longer starts right after the last one ended. A wrong lane split tap or a wrong shift enable corrupts `lane1`, or the second word of the frame, from the first bit it touches. A wrong width mask or wrong padding shows in the low-order bits of the very next word. A configuration latched at the wrong time shows up as a frame that mixes the old and new layouts. The bench checks the very next frame after a mid-frame change, so that error is caught there.

// File: rtl/lane_ser_pkg.sv
`timescale 1ns/1ps
package lane_ser_pkg;

  // Lane arrangement codes as seen on the lane_mode input
  typedef enum logic [1:0] {
    LM_DUAL   = 2'b00,   // each word split across both lanes
    LM_SINGLE = 2'b01,   // one lane per channel
    LM_HALF   = 2'b10,   // both channels in turn on lane 0
    LM_SPARE  = 2'b11    // treated as LM_SINGLE
  } lane_mode_e;

  // Output width codes; the all-zero code is the native width
  typedef enum logic [1:0] {
    RS_NATIVE = 2'b00,   // raw width
    RS_M4     = 2'b01,   // raw width minus 4
    RS_M2     = 2'b10,   // raw width minus 2
    RS_P2     = 2'b11    // raw width plus 2 (full filtered word)
  } res_sel_e;

  function automatic lane_mode_e norm_mode(input lane_mode_e m);
    return (m == LM_SPARE) ? LM_SINGLE : m;
  endfunction

endpackage

// File: rtl/ls_rst_sync.sv
`timescale 1ns/1ps
module ls_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ls_formatter.sv
`timescale 1ns/1ps
module ls_formatter
  import lane_ser_pkg::*;
#(
  parameter int RAW_W  = 18,
  parameter int WORD_W = RAW_W + 2
) (
  input  logic [WORD_W-1:0] smp,
  input  logic              filtered,
  input  res_sel_e          res,
  output logic [WORD_W-1:0] word_msb   // selected word, left-aligned, zeros below
);
  localparam int PAD_W    = WORD_W - RAW_W;
  localparam int DROP_M4  = WORD_W - (RAW_W - 4);
  localparam int DROP_M2  = WORD_W - (RAW_W - 2);
  localparam int DROP_NAT = WORD_W - RAW_W;

  logic [WORD_W-1:0] ext;

  // R2: raw samples are padded below, filtered words pass whole
  always_comb begin
    ext = filtered ? smp : {smp[RAW_W-1:0], {PAD_W{1'b0}}};
    unique case (res)
      RS_M4:     word_msb = (ext >> DROP_M4)  << DROP_M4;
      RS_M2:     word_msb = (ext >> DROP_M2)  << DROP_M2;
      RS_NATIVE: word_msb = (ext >> DROP_NAT) << DROP_NAT;
      default:   word_msb = ext;
    endcase
  end
endmodule

// File: rtl/ls_frame_seq.sv
`timescale 1ns/1ps
module ls_frame_seq
  import lane_ser_pkg::*;
#(
  parameter int RAW_W  = 18,
  parameter int WORD_W = RAW_W + 2,
  parameter int CNT_W  = $clog2(2 * WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lane_mode_e       mode_in,
  input  res_sel_e         res_in,
  output logic             running,
  output logic             load,
  output logic             phase,     // 0: first half of frame, 1: second half
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] len,
  output lane_mode_e       mode,
  output res_sel_e         res
);
  logic             loaded_q, loaded_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  lane_mode_e       mode_q, mode_d;
  res_sel_e         res_q, res_d;
  logic [CNT_W-1:0] bits;

  function automatic logic [CNT_W-1:0] res_bits(input res_sel_e r);
    unique case (r)
      RS_M4:     return CNT_W'(RAW_W - 4);
      RS_M2:     return CNT_W'(RAW_W - 2);
      RS_NATIVE: return CNT_W'(RAW_W);
      default:   return CNT_W'(RAW_W + 2);
    endcase
  endfunction

  // Next-state logic: R7 back-to-back frames, R8 settings taken only at load
  always_comb begin
    bits     = res_bits(res_q);
    len      = (mode_q == LM_HALF) ? CNT_W'(bits << 1) : bits;
    load     = !loaded_q || (cnt_q == len - CNT_W'(1));
    phase    = cnt_q >= (len >> 1);
    loaded_d = 1'b1;
    cnt_d    = load ? '0 : cnt_q + CNT_W'(1);
    mode_d   = load ? norm_mode(mode_in) : mode_q;
    res_d    = load ? res_in : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      cnt_q    <= '0;
      mode_q   <= LM_SINGLE;
      res_q    <= RS_NATIVE;
    end else begin
      loaded_q <= loaded_d;
      cnt_q    <= cnt_d;
      mode_q   <= mode_d;
      res_q    <= res_d;
    end
  end

  assign running = loaded_q;
  assign cnt     = cnt_q;
  assign mode    = mode_q;
  assign res     = res_q;
endmodule

// File: rtl/ls_lane_shift.sv
`timescale 1ns/1ps
module ls_lane_shift
  import lane_ser_pkg::*;
#(
  parameter int RAW_W  = 18,
  parameter int WORD_W = RAW_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              load,
  input  logic              phase,
  input  lane_mode_e        mode,
  input  res_sel_e          res,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic              lane0,
  output logic              lane1,
  output logic              fclk
);
  // Lane 1 tap: first bit of the lower half of a left-aligned word
  localparam int TAP_M4  = WORD_W - 1 - (RAW_W - 4) / 2;
  localparam int TAP_M2  = WORD_W - 1 - (RAW_W - 2) / 2;
  localparam int TAP_NAT = WORD_W - 1 - RAW_W / 2;
  localparam int TAP_P2  = WORD_W - 1 - (RAW_W + 2) / 2;

  logic [WORD_W-1:0] sa_q, sa_d, sb_q, sb_d, cur;
  logic              shift_a, shift_b, en_a, en_b;
  logic              low_tap, b0_d, b1_d, fc_d;
  logic              b0_q, b1_q, fc_q;

  always_comb begin
    shift_a = running && ((mode == LM_SINGLE) || !phase);
    shift_b = running && ((mode == LM_SINGLE) || phase);
    en_a    = load || shift_a;
    en_b    = load || shift_b;
    sa_d    = load ? word_a : (sa_q << 1);
    sb_d    = load ? word_b : (sb_q << 1);
    cur     = phase ? sb_q : sa_q;

    unique case (res)
      RS_M4:     low_tap = cur[TAP_M4];
      RS_M2:     low_tap = cur[TAP_M2];
      RS_NATIVE: low_tap = cur[TAP_NAT];
      default:   low_tap = cur[TAP_P2];
    endcase

    unique case (mode)
      LM_DUAL: begin            // R3
        b0_d = cur[WORD_W-1];
        b1_d = low_tap;
      end
      LM_HALF: begin            // R6
        b0_d = cur[WORD_W-1];
        b1_d = 1'b0;
      end
      default: begin            // R4
        b0_d = sa_q[WORD_W-1];
        b1_d = sb_q[WORD_W-1];
      end
    endcase

    b0_d = b0_d && running;
    b1_d = b1_d && running;
    fc_d = running && !phase;   // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q <= '0;
      sb_q <= '0;
    end else begin
      if (en_a) sa_q <= sa_d;
      if (en_b) sb_q <= sb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b0_q <= 1'b0;
      b1_q <= 1'b0;
      fc_q <= 1'b0;
    end else begin
      b0_q <= b0_d;
      b1_q <= b1_d;
      fc_q <= fc_d;
    end
  end

  assign lane0 = b0_q;
  assign lane1 = b1_q;
  assign fclk  = fc_q;
endmodule

// File: rtl/adc_lane_serializer.sv
`timescale 1ns/1ps
module adc_lane_serializer
  import lane_ser_pkg::*;
#(
  parameter int RAW_W   = 18,
  parameter int WORD_W  = RAW_W + 2,
  parameter int SYNC_ST = 2
) (
  input  logic              clk_bit,
  input  logic              arst_n,
  input  logic [WORD_W-1:0] smp_a,
  input  logic [WORD_W-1:0] smp_b,
  input  logic              filt_a,
  input  logic              filt_b,
  input  logic [1:0]        res_sel,
  input  logic [1:0]        lane_mode,
  output logic              lane0,
  output logic              lane1,
  output logic              fclk
);
  localparam int NUM_CH = 2;
  localparam int CNT_W  = $clog2(2 * WORD_W + 1);

  logic                           core_rst_n;
  logic [NUM_CH-1:0][WORD_W-1:0]  smp_v, word_v;
  logic [NUM_CH-1:0]              filt_v;
  logic                           running, load, phase;
  logic [CNT_W-1:0]               frame_cnt, frame_len;
  lane_mode_e                     cfg_mode;
  res_sel_e                       cfg_res;

  assign smp_v  = {smp_b, smp_a};
  assign filt_v = {filt_b, filt_a};

  ls_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk    (clk_bit),
    .arst_n (arst_n),
    .srst_n (core_rst_n)
  );

  ls_frame_seq #(.RAW_W(RAW_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
    .clk     (clk_bit),
    .rst_n   (core_rst_n),
    .mode_in (lane_mode_e'(lane_mode)),
    .res_in  (res_sel_e'(res_sel)),
    .running (running),
    .load    (load),
    .phase   (phase),
    .cnt     (frame_cnt),
    .len     (frame_len),
    .mode    (cfg_mode),
    .res     (cfg_res)
  );

  // Formatting follows the input width code so a word and its layout are
  // taken at the same edge (R7, R8)
  for (genvar c = 0; c < NUM_CH; c++) begin : g_fmt
    ls_formatter #(.RAW_W(RAW_W), .WORD_W(WORD_W)) u_fmt (
      .smp      (smp_v[c]),
      .filtered (filt_v[c]),
      .res      (res_sel_e'(res_sel)),
      .word_msb (word_v[c])
    );
  end

  ls_lane_shift #(.RAW_W(RAW_W), .WORD_W(WORD_W)) u_shift (
    .clk     (clk_bit),
    .rst_n   (core_rst_n),
    .running (running),
    .load    (load),
    .phase   (phase),
    .mode    (cfg_mode),
    .res     (cfg_res),
    .word_a  (word_v[0]),
    .word_b  (word_v[1]),
    .lane0   (lane0),
    .lane1   (lane1),
    .fclk    (fclk)
  );
endmodule

// File: rtl/ls_serializer_chk.sv
`timescale 1ns/1ps
module ls_serializer_chk
  import lane_ser_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             running,
  input logic             load,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] len,
  input lane_mode_e       mode,
  input res_sel_e         res,
  input logic             fclk,
  input logic             lane1
);
  p_fclk_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt == '0) |=> $rose(fclk));

  p_fclk_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt == (len >> 1)) |=> $fell(fclk));

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < len));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load) |=> ($stable(mode) && $stable(res)));

  p_lane1_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == LM_HALF) |=> !lane1);
endmodule

bind adc_lane_serializer ls_serializer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk_bit),
  .rst_n   (core_rst_n),
  .running (running),
  .load    (load),
  .cnt     (frame_cnt),
  .len     (frame_len),
  .mode    (cfg_mode),
  .res     (cfg_res),
  .fclk    (fclk),
  .lane1   (lane1)
);

// File: tb/adc_lane_serializer_bench.sv
`timescale 1ns/1ps
module adc_lane_serializer_bench;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] smp_a, smp_b;
  logic         filt_a, filt_b;
  logic [1:0]   res_sel, lane_mode;
  logic         lane0, lane1, fclk;
  logic         fclk_d;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // values applied mid-frame by run_frame
  int           nx_m, nx_r;
  logic [W-1:0] nx_a, nx_b;
  logic         nx_fa, nx_fb;

  always #2.5 clk = ~clk;
  always @(negedge clk) fclk_d <= fclk;

  adc_lane_serializer u_adc_lane_serializer (
    .clk_bit   (clk),
    .arst_n    (rst_n),
    .smp_a     (smp_a),
    .smp_b     (smp_b),
    .filt_a    (filt_a),
    .filt_b    (filt_b),
    .res_sel   (res_sel),
    .lane_mode (lane_mode),
    .lane0     (lane0),
    .lane1     (lane1),
    .fclk      (fclk)
  );

  function automatic int res_n(input int r);
    case (r)
      1: return 14;
      2: return 16;
      3: return 20;
      default: return 18;
    endcase
  endfunction

  function automatic logic [W-1:0] fmt(input logic [W-1:0] x, input logic f, input int r);
    logic [W-1:0] ext;
    ext = f ? x : {x[17:0], 2'b00};
    return ext >> (W - res_n(r));
  endfunction

  function automatic logic exp_lane(input int lane, input int m, input int r,
                                    input logic [W-1:0] wa, input logic [W-1:0] wb, input int i);
    int n, h, mm;
    n = res_n(r); h = n / 2; mm = (m == 3) ? 1 : m;
    case (mm)
      0: if (i < h) return (lane == 0) ? wa[n-1-i] : wa[h-1-i];
         else       return (lane == 0) ? wb[n-1-(i-h)] : wb[h-1-(i-h)];
      1: return (lane == 0) ? wa[n-1-i] : wb[n-1-i];
      default: if (lane == 1) return 1'b0;
               else return (i < n) ? wa[n-1-i] : wb[n-1-(i-n)];
    endcase
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R3";
      2: return "R6";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [W-1:0] pat(input int p, input int salt);
    case (p % 6)
      0: return 20'hFFFFF;
      1: return 20'h00000;
      2: return 20'hAAAAA ^ W'(salt);
      3: return 20'h80001;
      4: return W'(1) << ((salt * 7) % W);
      default: return W'(32'h12345 * (salt + 1));
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input int m, input int r, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic fa, input logic fb);
    lane_mode = 2'(m); res_sel = 2'(r);
    smp_a = a; smp_b = b; filt_a = fa; filt_b = fb;
  endtask

  task automatic wait_rise();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!(fclk === 1'b1 && fclk_d === 1'b0) && g < 200);
    if (g >= 200) check(1'b0, "R7", "no frame start", 40'd0, 40'd1);
  endtask

  // Observe one frame and compare it with the expected layout
  task automatic run_frame(input string extra, input int m, input int r,
                           input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic fa, input logic fb, input bit nowait, input int chg_at);
    int n = res_n(r);
    int len = (m == 2) ? 2 * n : n;
    logic [39:0] c0 = '0, c1 = '0, cf = '0, e0 = '0, e1 = '0, ef = '0;
    logic [W-1:0] wa = fmt(a, fa, r);
    logic [W-1:0] wb = fmt(b, fb, r);
    string tag = {extra, mode_tag(m)};
    if (nowait) begin
      @(negedge clk);
      check(fclk === 1'b1 && fclk_d === 1'b0, "R7", "next frame start",
            {39'd0, fclk}, 40'd1);
    end else begin
      wait_rise();
    end
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk);
      c0[i] = lane0; c1[i] = lane1; cf[i] = fclk;
      e0[i] = exp_lane(0, m, r, wa, wb, i);
      e1[i] = exp_lane(1, m, r, wa, wb, i);
      ef[i] = (i < len / 2);
      if (i == chg_at) drive(nx_m, nx_r, nx_a, nx_b, nx_fa, nx_fb);
    end
    check(c0 === e0, tag, "lane0", c0, e0);
    check(c1 === e1, tag, "lane1", c1, e1);
    check(cf === ef, {extra, "R5"}, "fclk", cf, ef);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1, 0, 20'h2C3A5, 20'h1F0F0, 1'b0, 1'b0);
    // R1: quiet while reset is held
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(lane0 === 1'b0 && lane1 === 1'b0 && fclk === 1'b0, "R1", "outputs in reset",
            {37'd0, lane0, lane1, fclk}, 40'd0);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(fclk === 1'b0, "R1", "fclk before first frame", {39'd0, fclk}, 40'd0);
    end
    @(negedge clk);
    check(fclk === 1'b1, "R1", "fclk on first frame bit", {39'd0, fclk}, 40'd1);
    check(lane0 === fmt(20'h2C3A5, 1'b0, 0)[17], "R1", "first lane0 bit",
          {39'd0, lane0}, {39'd0, fmt(20'h2C3A5, 1'b0, 0)[17]});

    // Sweep: every mode code, every width code, several patterns and flags
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        for (int p = 0; p < 6; p++) begin
          for (int f = 0; f < 2; f++) begin
            logic [W-1:0] a = pat(p, m * 4 + r);
            logic [W-1:0] b = ~pat(p + 1, r + 3 * f);
            logic fa = f[0];
            logic fb = ~f[0] ^ p[0];
            drive(m, r, a, b, fa, fb);
            wait_rise();
            run_frame("R2 ", m, r, a, b, fa, fb, 1'b0, -1);
          end
        end
      end
    end

    // R8: change everything mid-frame; old frame intact, next one new
    drive(1, 0, 20'h3A5C3, 20'h0FF00, 1'b0, 1'b0);
    nx_m = 2; nx_r = 3; nx_a = 20'hC3C3C; nx_b = 20'h5A5A5; nx_fa = 1'b1; nx_fb = 1'b1;
    wait_rise();
    run_frame("R8 ", 1, 0, 20'h3A5C3, 20'h0FF00, 1'b0, 1'b0, 1'b0, 3);
    run_frame("R8 ", 2, 3, 20'hC3C3C, 20'h5A5A5, 1'b1, 1'b1, 1'b1, -1);

    nx_m = 0; nx_r = 1; nx_a = 20'h6D2E1; nx_b = 20'h1B7C4; nx_fa = 1'b0; nx_fb = 1'b1;
    run_frame("R8 ", 2, 3, 20'hC3C3C, 20'h5A5A5, 1'b1, 1'b1, 1'b1, 5);
    run_frame("R8 ", 0, 1, 20'h6D2E1, 20'h1B7C4, 1'b0, 1'b1, 1'b1, -1);
    run_frame("R7 ", 0, 1, 20'h6D2E1, 20'h1B7C4, 1'b0, 1'b1, 1'b1, -1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule